// File: doc/BRIEF.md
# Flash Block Transfer Sequencer

This block moves quadlet buffers between a local buffer RAM and a device flash. The flash is reached only through a small register window on a synchronous register bus. A requester hands over one request at a time: read, write, revision query, or one of three region erases. The sequencer cuts a read or write into sub-blocks of at most `SUB_Q` quadlets. For each sub-block it loads a flash address/byte-size register pair and writes a per-operation command code to one control register. It then waits a command-dependent minimum time and polls the control register until it reads back zero.

Write data is copied from the RAM into the data window before the command is issued. Read data, and the revision word, are copied from the window into the RAM only after the not-busy condition has been seen. The requester gets a one-cycle done or error pulse. Error covers an unknown operation and a busy flag that never clears within the poll limit.

Top module: `flash_seq`

## Requirements
- R1: `req_op` selects the command code written to the control register (`CTRL_ADDR`): 0 = read → 0x2, 1 = write → 0x1, 2 = revision → 0xF, 3 = erase volume region → 0xE, 4 = erase settings → 0xD, 5 = erase configuration → 0xC.
- R2: A read or write of `req_len` quadlets is issued as ceil(len/SUB_Q) commands. Every sub-block but the last carries SUB_Q quadlets, and the last carries only the remainder, with no padding. The byte-size field is the sub-block quadlet count times 4.
- R3: The flash address of sub-block k is `req_flash_addr + k*SUB_Q*4`. Its RAM word address is `req_ram_addr + k*SUB_Q`.
- R4: For a write, the sub-block data is written to window addresses `PAIR_ADDR+2+i` before that sub-block's command, so that the flash receives exactly the RAM contents.
- R5: Before each read or write command, the flash address is written to `PAIR_ADDR` and the byte size to `PAIR_ADDR+1`, giving two pair writes per sub-block.
- R6: The first read of the control register after a command comes no earlier than `WAIT_RW` cycles after a read, write or revision command, and no earlier than `WAIT_ERASE` cycles after an erase command.
- R7: The device counts as ready when a control-register read returns zero. Polling repeats while the value is non-zero. Window data is read only after a zero has been seen for the current command.
- R8: If `POLL_MAX` consecutive polls all read non-zero, the request ends with `resp_error`, and no further bus access occurs.
- R9: A revision request issues code 0xF with no pair writes, and stores window word 0 into the RAM at `req_ram_addr`.
- R10: `req_ready` is low from the cycle after acceptance until the cycle in which `resp_done` or `resp_error` pulses. The two responses are never high together.
- R11: An operation code of 6 or 7 produces `resp_error` in the cycle after acceptance, with no bus or RAM access. A read or write of length 0 produces `resp_done` with no access.
- R12: An erase issues only its command code, with no pair, window or RAM access, and completes with `resp_done` once the device is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 3 | Operation code |
| req_flash_addr | input | FA_W | Flash byte address |
| req_ram_addr | input | RAM_AW | Buffer RAM word address |
| req_len | input | LEN_W | Transfer length in quadlets |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_error | output | 1 | One-cycle error pulse |
| bus_req | output | 1 | Register bus access strobe |
| bus_we | output | 1 | Register bus write (else read) |
| bus_addr | output | REG_AW | Register quadlet address |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Read data, valid the cycle after a read |
| ram_re | output | 1 | Buffer RAM read enable |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_addr | output | RAM_AW | Buffer RAM word address |
| ram_wdata | output | 32 | Buffer RAM write data |
| ram_rdata | input | 32 | Buffer RAM read data, one cycle latency |

## Verification
The bench shrinks the minimum waits to `WAIT_RW`=12 and `WAIT_ERASE`=40 cycles and sets `POLL_MAX`=8, with the default 32-quadlet sub-block. Its flash stub holds busy for longer than each wait, so several non-zero polls happen on every command, and a stuck-busy mode reaches the timeout within a few dozen cycles. Random lengths up to 100 quadlets cover one to four sub-blocks, including exact multiples of 32 and a single quadlet.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  localparam int QUAD_W = 32;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_REV       = 3'd2,
    OP_ERASE_VOL = 3'd3,
    OP_ERASE_SET = 3'd4,
    OP_ERASE_CFG = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FILL_RD, S_FILL_WR, S_PAIR_A, S_PAIR_S, S_CMD, S_WAIT,
    S_POLL_RD, S_POLL_CHK, S_DRAIN_RD, S_DRAIN_WR, S_NEXT
  } state_e;

  function automatic logic op_known(logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic op_erase(logic [2:0] op);
    return (op == OP_ERASE_VOL) || (op == OP_ERASE_SET) || (op == OP_ERASE_CFG);
  endfunction

  function automatic logic op_bulk(logic [2:0] op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

  function automatic logic [3:0] cmd_code(logic [2:0] op);
    case (op)
      OP_READ:      return 4'h2;
      OP_WRITE:     return 4'h1;
      OP_REV:       return 4'hF;
      OP_ERASE_VOL: return 4'hE;
      OP_ERASE_SET: return 4'hD;
      default:      return 4'hC;
    endcase
  endfunction
endpackage

// File: rtl/flseq_chunker.sv
module flseq_chunker #(
  parameter int SUB_Q  = 32,
  parameter int LEN_W  = 12,
  parameter int RAM_AW = 10,
  parameter int FA_W   = 32,
  localparam int CQ_W  = $clog2(SUB_Q + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FA_W-1:0]   ld_faddr,
  input  logic [RAM_AW-1:0] ld_raddr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              step_word,
  input  logic              next_chunk,
  output logic [CQ_W-1:0]   word_idx,
  output logic              word_last,
  output logic              chunk_last,
  output logic [FA_W-1:0]   cur_faddr,
  output logic [RAM_AW-1:0] cur_raddr,
  output logic [31:0]       size_bytes
);
  logic [LEN_W-1:0]  remain;
  logic [RAM_AW-1:0] raddr_base;
  logic [CQ_W-1:0]   chunk_q;

  always_comb begin
    if (remain > LEN_W'(SUB_Q)) chunk_q = CQ_W'(SUB_Q);
    else                        chunk_q = remain[CQ_W-1:0];
  end

  assign chunk_last = remain <= LEN_W'(SUB_Q);
  assign word_last  = word_idx == CQ_W'(chunk_q - 1'b1);
  assign cur_raddr  = raddr_base + RAM_AW'(word_idx);
  assign size_bytes = {{(32-CQ_W-2){1'b0}}, chunk_q, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      remain     <= '0;
      cur_faddr  <= '0;
      raddr_base <= '0;
      word_idx   <= '0;
    end else if (load) begin
      remain     <= ld_len;
      cur_faddr  <= ld_faddr;
      raddr_base <= ld_raddr;
      word_idx   <= '0;
    end else if (next_chunk) begin
      remain     <= remain - LEN_W'(chunk_q);
      cur_faddr  <= cur_faddr + FA_W'(SUB_Q * 4);
      raddr_base <= raddr_base + RAM_AW'(SUB_Q);
      word_idx   <= '0;
    end else if (step_word) begin
      word_idx   <= word_idx + 1'b1;
    end
  end
endmodule

// File: rtl/flseq_timer.sv
module flseq_timer #(
  parameter int WAIT_RW    = 250000,
  parameter int WAIT_ERASE = 62500000,
  parameter int POLL_MAX   = 1000,
  localparam int WMAX      = (WAIT_ERASE > WAIT_RW) ? WAIT_ERASE : WAIT_RW,
  localparam int WCNT_W    = $clog2(WMAX + 1),
  localparam int PCNT_W    = $clog2(POLL_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  input  logic poll_inc,
  output logic wait_done,
  output logic poll_last
);
  logic [WCNT_W-1:0] wcnt;
  logic [PCNT_W-1:0] pcnt;

  assign wait_done = wcnt == '0;
  assign poll_last = pcnt == PCNT_W'(POLL_MAX - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
      pcnt <= '0;
    end else if (start) begin
      wcnt <= long_sel ? WCNT_W'(WAIT_ERASE) : WCNT_W'(WAIT_RW);
      pcnt <= '0;
    end else begin
      if (wcnt != '0) wcnt <= wcnt - 1'b1;
      if (poll_inc)   pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/flseq_port.sv
module flseq_port
  import flseq_pkg::*;
#(
  parameter int REG_AW    = 8,
  parameter int RAM_AW    = 10,
  parameter int FA_W      = 32,
  parameter int CTRL_ADDR = 8,
  parameter int PAIR_ADDR = 32,
  parameter int CQ_W      = 6,
  localparam int WIN_ADDR = PAIR_ADDR + 2
) (
  input  state_e            state,
  input  logic [3:0]        code,
  input  logic [FA_W-1:0]   faddr,
  input  logic [31:0]       size_bytes,
  input  logic [CQ_W-1:0]   idx,
  input  logic [RAM_AW-1:0] raddr,
  input  logic [31:0]       ram_rdata,
  input  logic [31:0]       bus_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [REG_AW-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              ram_re,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [31:0]       ram_wdata
);
  logic [REG_AW-1:0] win_at;
  assign win_at    = REG_AW'(WIN_ADDR) + REG_AW'(idx);
  assign ram_addr  = raddr;
  assign ram_wdata = bus_rdata;
  assign ram_re    = state == S_FILL_RD;
  assign ram_we    = state == S_DRAIN_WR;

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      S_FILL_WR: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = win_at; bus_wdata = ram_rdata;
      end
      S_PAIR_A: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = REG_AW'(PAIR_ADDR);
        bus_wdata = QUAD_W'(faddr);
      end
      S_PAIR_S: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = REG_AW'(PAIR_ADDR + 1);
        bus_wdata = size_bytes;
      end
      S_CMD: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = REG_AW'(CTRL_ADDR);
        bus_wdata = {28'd0, code};
      end
      S_POLL_RD: begin
        bus_req = 1'b1; bus_addr = REG_AW'(CTRL_ADDR);
      end
      S_DRAIN_RD: begin
        bus_req = 1'b1; bus_addr = win_at;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flseq_pkg::*;
#(
  parameter int SUB_Q      = 32,
  parameter int LEN_W      = 12,
  parameter int RAM_AW     = 10,
  parameter int FA_W       = 32,
  parameter int REG_AW     = 8,
  parameter int CTRL_ADDR  = 8,
  parameter int PAIR_ADDR  = 32,
  parameter int WAIT_RW    = 250000,
  parameter int WAIT_ERASE = 62500000,
  parameter int POLL_MAX   = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [FA_W-1:0]   req_flash_addr,
  input  logic [RAM_AW-1:0] req_ram_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              resp_done,
  output logic              resp_error,
  output logic              bus_req,
  output logic              bus_we,
  output logic [REG_AW-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              ram_re,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata
);
  localparam int CQ_W = $clog2(SUB_Q + 1);

  state_e            state;
  logic [2:0]        op_q;
  logic              ck_load, ck_step, ck_next;
  logic [CQ_W-1:0]   word_idx;
  logic              word_last, chunk_last;
  logic [FA_W-1:0]   cur_faddr;
  logic [RAM_AW-1:0] cur_raddr;
  logic [31:0]       size_bytes;
  logic              tm_start, tm_inc, wait_done, poll_last;
  logic              accept, zero_bulk, dev_ready;
  logic [LEN_W-1:0]  ld_len;

  assign req_ready = state == S_IDLE;
  assign accept    = req_valid && req_ready;
  assign zero_bulk = op_bulk(req_op) && (req_len == '0);
  assign ld_len    = op_bulk(req_op) ? req_len : LEN_W'(1);
  assign dev_ready = bus_rdata == '0;

  assign ck_load  = accept && op_known(req_op) && !zero_bulk;
  assign ck_step  = ((state == S_FILL_WR) || (state == S_DRAIN_WR)) && !word_last;
  assign ck_next  = (state == S_NEXT) && !chunk_last;
  assign tm_start = state == S_CMD;
  assign tm_inc   = (state == S_POLL_CHK) && !dev_ready;

  flseq_chunker #(.SUB_Q(SUB_Q), .LEN_W(LEN_W), .RAM_AW(RAM_AW), .FA_W(FA_W)) u_chunk (
    .clk(clk), .rst(rst), .load(ck_load), .ld_faddr(req_flash_addr),
    .ld_raddr(req_ram_addr), .ld_len(ld_len), .step_word(ck_step),
    .next_chunk(ck_next), .word_idx(word_idx), .word_last(word_last),
    .chunk_last(chunk_last), .cur_faddr(cur_faddr), .cur_raddr(cur_raddr),
    .size_bytes(size_bytes)
  );

  flseq_timer #(.WAIT_RW(WAIT_RW), .WAIT_ERASE(WAIT_ERASE), .POLL_MAX(POLL_MAX)) u_timer (
    .clk(clk), .rst(rst), .start(tm_start), .long_sel(op_erase(op_q)),
    .poll_inc(tm_inc), .wait_done(wait_done), .poll_last(poll_last)
  );

  flseq_port #(.REG_AW(REG_AW), .RAM_AW(RAM_AW), .FA_W(FA_W), .CTRL_ADDR(CTRL_ADDR),
               .PAIR_ADDR(PAIR_ADDR), .CQ_W(CQ_W)) u_port (
    .state(state), .code(cmd_code(op_q)), .faddr(cur_faddr), .size_bytes(size_bytes),
    .idx(word_idx), .raddr(cur_raddr), .ram_rdata(ram_rdata), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= '0;
      resp_done  <= 1'b0;
      resp_error <= 1'b0;
    end else begin
      resp_done  <= 1'b0;
      resp_error <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          op_q <= req_op;
          if (!op_known(req_op))  resp_error <= 1'b1;
          else if (zero_bulk)     resp_done  <= 1'b1;
          else if (req_op == OP_WRITE) state <= S_FILL_RD;
          else if (req_op == OP_READ)  state <= S_PAIR_A;
          else                         state <= S_CMD;
        end
        S_FILL_RD:  state <= S_FILL_WR;
        S_FILL_WR:  state <= word_last ? S_PAIR_A : S_FILL_RD;
        S_PAIR_A:   state <= S_PAIR_S;
        S_PAIR_S:   state <= S_CMD;
        S_CMD:      state <= S_WAIT;
        S_WAIT:     if (wait_done) state <= S_POLL_RD;
        S_POLL_RD:  state <= S_POLL_CHK;
        S_POLL_CHK: begin
          if (dev_ready) begin
            if ((op_q == OP_READ) || (op_q == OP_REV)) state <= S_DRAIN_RD;
            else                                       state <= S_NEXT;
          end else if (poll_last) begin
            resp_error <= 1'b1;
            state      <= S_IDLE;
          end else begin
            state <= S_POLL_RD;
          end
        end
        S_DRAIN_RD: state <= S_DRAIN_WR;
        S_DRAIN_WR: state <= word_last ? S_NEXT : S_DRAIN_RD;
        S_NEXT: begin
          if (chunk_last) begin
            resp_done <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= (op_q == OP_WRITE) ? S_FILL_RD : S_PAIR_A;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int SUB_Q      = 32,
  parameter int REG_AW     = 8,
  parameter int CTRL_ADDR  = 8,
  parameter int PAIR_ADDR  = 32,
  parameter int WAIT_RW    = 250000,
  parameter int WAIT_ERASE = 62500000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              resp_done,
  input logic              resp_error,
  input logic              bus_req,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              ram_re,
  input logic              ram_we
);
  logic [31:0] since_cmd;
  logic        long_q;
  logic        ctrl_wr, ctrl_rd;

  assign ctrl_wr = bus_req && bus_we && (bus_addr == REG_AW'(CTRL_ADDR));
  assign ctrl_rd = bus_req && !bus_we && (bus_addr == REG_AW'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      since_cmd <= '0;
      long_q    <= 1'b0;
    end else if (ctrl_wr) begin
      since_cmd <= '0;
      long_q    <= (bus_wdata[3:0] == 4'hE) || (bus_wdata[3:0] == 4'hD) ||
                   (bus_wdata[3:0] == 4'hC);
    end else if (since_cmd != 32'hFFFF_FFFF) begin
      since_cmd <= since_cmd + 1'b1;
    end
  end

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready || resp_done || resp_error));

  assert_resp_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(resp_done && resp_error));

  assert_size_field_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == REG_AW'(PAIR_ADDR + 1)) |->
      (bus_wdata[1:0] == 2'b00 && bus_wdata != '0 && bus_wdata <= 32'(SUB_Q * 4)));

  assert_min_wait_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |-> (since_cmd >= (long_q ? 32'(WAIT_ERASE) : 32'(WAIT_RW))));

  assert_window_span_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_addr >= REG_AW'(PAIR_ADDR + 2)) |->
      (32'(bus_addr) < 32'(PAIR_ADDR + 2 + SUB_Q)));

  assert_ram_port_R9: assert property (@(posedge clk) disable iff (rst)
    !(ram_re && ram_we));

  assert_bad_op_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op > 3'd5) |=> (resp_error && !bus_req));
endmodule

bind flash_seq flash_seq_chk #(
  .SUB_Q(SUB_Q), .REG_AW(REG_AW), .CTRL_ADDR(CTRL_ADDR), .PAIR_ADDR(PAIR_ADDR),
  .WAIT_RW(WAIT_RW), .WAIT_ERASE(WAIT_ERASE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .resp_done(resp_done), .resp_error(resp_error), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ram_re(ram_re), .ram_we(ram_we)
);

// File: tb/sim_flash_seq.sv
`timescale 1ns/1ps
module sim_flash_seq;
  localparam int SUB_Q = 32, CTRL = 8, PAIR = 32, WIN = PAIR + 2;
  localparam int WRW = 12, WER = 40, PMAX = 8;
  localparam int BUSY_RW = 18, BUSY_ER = 46;
  localparam logic [31:0] REV_WORD = 32'h5EC0_0A17;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [31:0] req_flash_addr = '0;
  logic [9:0] req_ram_addr = '0;
  logic [11:0] req_len = '0;
  logic resp_done, resp_error, bus_req, bus_we, ram_re, ram_we;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0, ram_wdata, ram_rdata = '0;
  logic [9:0] ram_addr;

  always #4 clk = ~clk;

  flash_seq #(.WAIT_RW(WRW), .WAIT_ERASE(WER), .POLL_MAX(PMAX),
              .CTRL_ADDR(CTRL), .PAIR_ADDR(PAIR)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_flash_addr(req_flash_addr), .req_ram_addr(req_ram_addr), .req_len(req_len),
    .resp_done(resp_done), .resp_error(resp_error), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_re(ram_re),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata));

  // flash stub and buffer RAM
  logic [31:0] flash_m [0:1023];
  logic [31:0] ram_m [0:1023];
  logic [31:0] win [0:SUB_Q-1];
  logic [31:0] pair_a, pair_s;
  logic [31:0] code_log [0:63], size_log [0:63], addr_log [0:63];
  int cyc = 0, cmd_cyc = 0, busy_cnt = 0, n_cmd = 0, n_pair = 0, n_poll = 0;
  int n_access = 0, n_ramwr = 0, viol_wait = 0, viol_win = 0;
  bit stuck = 0, seen_ready = 0, last_long = 0;
  int n_chk = 0, n_fail = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (bus_req) begin
      n_access = n_access + 1;
      if (bus_we) begin
        if (bus_addr == 8'(CTRL)) begin
          cmd_cyc = cyc; seen_ready = 0;
          last_long = (bus_wdata[3:0] >= 4'hC && bus_wdata[3:0] <= 4'hE);
          busy_cnt = last_long ? BUSY_ER : BUSY_RW;
          if (n_cmd < 64) begin
            code_log[n_cmd] = bus_wdata; size_log[n_cmd] = pair_s; addr_log[n_cmd] = pair_a;
          end
          n_cmd = n_cmd + 1;
          if (bus_wdata[3:0] == 4'h1)
            for (int i = 0; i < int'(pair_s / 4) && i < SUB_Q; i++)
              flash_m[((pair_a >> 2) + i) & 1023] = win[i];
          else if (bus_wdata[3:0] == 4'h2)
            for (int i = 0; i < int'(pair_s / 4) && i < SUB_Q; i++)
              win[i] = flash_m[((pair_a >> 2) + i) & 1023];
          else if (bus_wdata[3:0] == 4'hF)
            win[0] = REV_WORD;
        end else if (bus_addr == 8'(PAIR)) begin
          pair_a = bus_wdata; n_pair = n_pair + 1;
        end else if (bus_addr == 8'(PAIR + 1)) begin
          pair_s = bus_wdata; n_pair = n_pair + 1;
        end else if (bus_addr >= 8'(WIN) && bus_addr < 8'(WIN + SUB_Q)) begin
          win[bus_addr - 8'(WIN)] = bus_wdata;
        end
      end else begin
        if (bus_addr == 8'(CTRL)) begin
          n_poll = n_poll + 1;
          if (cyc - cmd_cyc < (last_long ? WER : WRW)) viol_wait = viol_wait + 1;
          if (busy_cnt > 0 || stuck) bus_rdata <= 32'h1;
          else begin bus_rdata <= 32'h0; seen_ready = 1; end
        end else if (bus_addr >= 8'(WIN) && bus_addr < 8'(WIN + SUB_Q)) begin
          if (!seen_ready) viol_win = viol_win + 1;
          bus_rdata <= win[bus_addr - 8'(WIN)];
        end
      end
    end
    if (ram_re) ram_rdata <= ram_m[ram_addr];
    if (ram_we) begin ram_m[ram_addr] = ram_wdata; n_ramwr = n_ramwr + 1; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_logs();
    n_cmd = 0; n_pair = 0; n_poll = 0; n_access = 0; n_ramwr = 0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] fa, input int ra,
                        input int len, output logic e, output logic rdy_after);
    int t;
    clr_logs();
    @(negedge clk);
    req_valid = 1; req_op = op; req_flash_addr = fa; req_ram_addr = 10'(ra); req_len = 12'(len);
    @(negedge clk);
    req_valid = 0; rdy_after = req_ready;
    t = 0;
    while (!(resp_done || resp_error) && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) chk(0, "R10", "request never completed", t, 0);
    e = resp_error;
  endtask

  function automatic int log_errs(int len, logic [31:0] fa, logic [3:0] code);
    int nsub = (len + SUB_Q - 1) / SUB_Q;
    int bad = (n_cmd != nsub) ? 1 : 0;
    for (int k = 0; k < nsub && k < 64; k++) begin
      int q = (len - SUB_Q * k) > SUB_Q ? SUB_Q : len - SUB_Q * k;
      if (size_log[k] != 32'(q * 4) || addr_log[k] != fa + 32'(128 * k) ||
          code_log[k][3:0] != code) bad++;
    end
    return bad;
  endfunction

  function automatic int cmp_mem(logic [31:0] fa, int ra, int len);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (flash_m[((fa >> 2) + i) & 1023] != ram_m[(ra + i) & 1023]) bad++;
    return bad;
  endfunction

  task automatic bulk_pair(input int len, input logic [31:0] fa, input int src, input int dst);
    logic e, r;
    int bad;
    for (int i = 0; i < len; i++) ram_m[src + i] = $urandom;
    run_op(3'd1, fa, src, len, e, r);
    chk(!e, "R1", "write completes", e, 0);
    chk(!r, "R10", "ready low while busy", r, 0);
    bad = log_errs(len, fa, 4'h1);
    chk(bad == 0, "R2", "write sub-block sizes/addresses (R3)", bad, 0);
    chk(n_pair == 2 * ((len + 31) / 32), "R5", "pair writes for write", n_pair, 2 * ((len + 31) / 32));
    bad = cmp_mem(fa, src, len);
    chk(bad == 0, "R4", "flash holds written data", bad, 0);
    for (int i = 0; i < len; i++) ram_m[dst + i] = 32'hDEAD_0000;
    run_op(3'd0, fa, dst, len, e, r);
    chk(!e, "R1", "read completes", e, 0);
    bad = log_errs(len, fa, 4'h2);
    chk(bad == 0, "R2", "read sub-block sizes/addresses (R3)", bad, 0);
    chk(n_ramwr == len, "R2", "read RAM writes unpadded", n_ramwr, len);
    bad = cmp_mem(fa, dst, len);
    chk(bad == 0, "R7", "read data reaches RAM", bad, 0);
  endtask

  initial begin
    logic e, r;
    int snap;
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) begin flash_m[i] = 32'hFFFF_FFFF; ram_m[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !resp_done && !resp_error && !bus_req, "R10", "reset state idle",
        {req_ready, resp_done, resp_error, bus_req}, 4'b1000);

    // directed lengths: partial, exact multiple, single, multi
    bulk_pair(70, 32'h0000_0100, 0, 512);
    bulk_pair(32, 32'h0000_0800, 0, 512);
    bulk_pair(1, 32'h0000_0C00, 0, 512);
    bulk_pair(64, 32'h0000_0400, 0, 512);

    // revision
    ram_m[300] = 0;
    run_op(3'd2, 32'h0, 300, 0, e, r);
    chk(!e && ram_m[300] == REV_WORD, "R9", "revision word stored", ram_m[300], REV_WORD);
    chk(n_pair == 0 && code_log[0][3:0] == 4'hF && n_cmd == 1, "R9", "revision command only",
        code_log[0][3:0], 4'hF);

    // erases
    for (int k = 3; k <= 5; k++) begin
      logic [3:0] exp_c;
      exp_c = (k == 3) ? 4'hE : (k == 4) ? 4'hD : 4'hC;
      run_op(3'(k), 32'h0, 0, 0, e, r);
      chk(!e && n_cmd == 1 && code_log[0][3:0] == exp_c, "R1", "erase code", code_log[0][3:0], exp_c);
      chk(n_pair == 0 && n_ramwr == 0 && n_access == 1 + n_poll, "R12", "erase touches ctrl only",
          n_access, 1 + n_poll);
    end
    chk(viol_wait == 0, "R6", "minimum wait before polling", viol_wait, 0);
    chk(viol_win == 0, "R7", "window read only after ready", viol_win, 0);

    // invalid op and zero length
    run_op(3'd6, 32'h0, 0, 4, e, r);
    chk(e && r && n_access == 0 && n_ramwr == 0, "R11", "bad op rejected", n_access, 0);
    run_op(3'd1, 32'h0, 0, 0, e, r);
    chk(!e && resp_done && n_access == 0, "R11", "zero-length write done", n_access, 0);

    // stuck busy timeout
    stuck = 1;
    run_op(3'd0, 32'h40, 600, 5, e, r);
    chk(e, "R8", "timeout raises error", e, 1);
    chk(n_poll == PMAX, "R8", "poll count at timeout", n_poll, PMAX);
    snap = n_access;
    repeat (20) @(negedge clk);
    chk(n_access == snap && n_ramwr == 0, "R8", "no access after timeout", n_access, snap);
    stuck = 0;

    // random transfers
    for (int it = 0; it < 10; it++) begin
      int len = 1 + int'($urandom % 100);
      logic [31:0] fa = 32'(($urandom % (1024 - len)) * 4);
      bulk_pair(len, fa, 0, 512);
    end
    chk(viol_wait == 0, "R6", "minimum wait, random phase", viol_wait, 0);
    chk(viol_win == 0, "R7", "window order, random phase", viol_win, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule